// File: doc/BRIEF.md
# Out-of-Order Instruction Window with Register Renaming

This block holds the instructions that a decoder has handed to an out-of-order core, from the moment they are decoded until they retire. Each decoded instruction takes one slot in a circular buffer. Its two source registers are looked up in a small alias table. A source either resolves at once to a value or is left waiting on the slot number (the tag) of the instruction that will produce it. The execution side is offered one ready slot per cycle, and it returns results as tag/value pairs on a broadcast bus. Every waiting source that holds a matching tag picks up the value.

Slots retire strictly in the order they were allocated. A retiring slot writes its result into the architectural register file. If the oldest slot carries a non-zero fault code, nothing is retired. Every slot in flight is discarded in one step, the alias table is emptied, and the fault is reported. This gives precise exceptions.

The tag of a slot is its index, 0 to DEPTH-1, and DEPTH must be a power of two. A source register with no live alias reads the architectural file. Fault code 0 means no fault. The architectural registers reset to zero.

Top module: `rob_core`

## Requirements
- R1: Reset state. After reset the window is empty: alloc_ready is 1, alloc_tag is 0, and issue_valid, cmt_valid and exc_valid are 0.
- R2: Slot allocation. alloc_tag gives the slot that the next accepted instruction takes. It advances by one, modulo DEPTH, on each accepted allocation. When all DEPTH slots are in flight, alloc_ready is 0 and a request is ignored: no slot is written and alloc_tag does not move.
- R3: Sources without a live alias. A source register with no live alias takes its value from the architectural file and is ready at once. The instruction may be offered for issue in the cycle after it is allocated.
- R4: Sources with a live alias. A source aliased to a slot that has not yet produced a result waits on that tag. It becomes ready at the clock edge where a broadcast with that tag is applied, and it takes the broadcast value.
- R5: Same-cycle and earlier results. A source whose producer's result is broadcast in the same cycle as the allocation captures that value. So does a source whose producer has already completed. Such a source is ready immediately.
- R6: Issue selection. issue_valid offers only a slot that is in flight, has not been accepted before, has no result yet, and has both sources ready. Of the eligible slots, the one oldest in program order is offered. A slot accepted with issue_accept is never offered again.
- R7: In-order retirement. Slots retire in allocation order. A result broadcast at clock edge k for the oldest slot shows on cmt_valid/cmt_data/cmt_dst after edge k+1. The architectural register is updated at that same edge.
- R8: Fault flush. When the oldest slot completes with a non-zero fault code, exc_valid pulses with that slot's tag and code, and nothing retires. Every slot in flight is discarded, so the window is empty and alloc_tag equals the faulting slot's tag.
- R9: Alias table after a flush. All aliases are invalid after a flush, so later readers of any register get the architectural value.
- R10: Alias removal at retirement. When a slot retires, the alias of its destination register is removed only if that alias still names the retiring slot. A reader allocated afterwards keeps waiting on a younger writer of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decoder presents an instruction |
| alloc_op | input | OPW | Operation code stored with the slot |
| alloc_src1 | input | log2(NREG) | First source register |
| alloc_src2 | input | log2(NREG) | Second source register |
| alloc_dst_en | input | 1 | Instruction writes a register |
| alloc_dst | input | log2(NREG) | Destination register |
| alloc_ready | output | 1 | Window can accept an instruction this cycle |
| alloc_tag | output | log2(DEPTH) | Slot the next accepted instruction takes |
| issue_accept | input | 1 | Execution side takes the offered slot |
| issue_valid | output | 1 | A ready slot is offered |
| issue_tag | output | log2(DEPTH) | Offered slot |
| issue_op | output | OPW | Operation of the offered slot |
| issue_val1 | output | XLEN | First operand value |
| issue_val2 | output | XLEN | Second operand value |
| res_valid | input | 1 | Result broadcast is present |
| res_tag | input | log2(DEPTH) | Slot the result belongs to |
| res_data | input | XLEN | Result value |
| res_cause | input | CAUSE_W | Fault code, 0 for none |
| cmt_valid | output | 1 | A slot retired at the last edge |
| cmt_tag | output | log2(DEPTH) | Retired slot |
| cmt_dst_en | output | 1 | Retired slot wrote a register |
| cmt_dst | output | log2(NREG) | Register written |
| cmt_data | output | XLEN | Value written |
| exc_valid | output | 1 | A fault flushed the window at the last edge |
| exc_tag | output | log2(DEPTH) | Faulting slot |
| exc_cause | output | CAUSE_W | Fault code |

## Verification
Two situations are hard to reach from the ports. The first is a reader allocated in exactly the cycle its producer's result is on the bus. The bench issues a lone producer, then drives the reader's allocation and the producer's broadcast on the same falling edge. The second is a register with two writers in flight, where the older writer retires while the younger one is still running. The bench accepts both writers but broadcasts only the older result. It waits for that retirement, then allocates a reader and confirms that the reader is not offered until the younger result arrives. A mixed program with write-after-write and write-after-read reuse is also run. Its results are returned in last-in first-out order, and the retired values are compared against a sequential model of the program.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // How an operand is resolved at allocation time
  typedef enum logic [1:0] {
    SRC_ARCH  = 2'd0,  // no live alias: architectural register file
    SRC_DONE  = 2'd1,  // producer slot already holds its result
    SRC_BCAST = 2'd2,  // producer result is on the bus this cycle
    SRC_WAIT  = 2'd3   // wait for a broadcast carrying the tag
  } src_kind_e;
endpackage

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
  parameter int NREG  = 8,
  parameter int TAG_W = 3,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [RW-1:0]    rd_a,
  input  logic [RW-1:0]    rd_b,
  output logic             rd_a_valid,
  output logic [TAG_W-1:0] rd_a_tag,
  output logic             rd_b_valid,
  output logic [TAG_W-1:0] rd_b_tag,
  input  logic             set_en,
  input  logic [RW-1:0]    set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [RW-1:0]    clr_reg,
  input  logic [TAG_W-1:0] clr_tag
);
  logic [NREG-1:0]  alias_v;
  logic [TAG_W-1:0] alias_t [NREG];

  assign rd_a_valid = alias_v[rd_a];
  assign rd_a_tag   = alias_t[rd_a];
  assign rd_b_valid = alias_v[rd_b];
  assign rd_b_tag   = alias_t[rd_b];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      alias_v <= '0;
    end else begin
      // drop the alias only when it still names the retiring slot
      if (clr_en && alias_v[clr_reg] && alias_t[clr_reg] == clr_tag &&
          !(set_en && set_reg == clr_reg))
        alias_v[clr_reg] <= 1'b0;
      if (set_en)
        alias_v[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en && !flush)
      alias_t[set_reg] <= set_tag;
  end
endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   rd_a,
  input  logic [RW-1:0]   rd_b,
  output logic [XLEN-1:0] rd_a_data,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_reg,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] regs [NREG];

  assign rd_a_data = regs[rd_a];
  assign rd_b_data = regs[rd_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_reg] <= wr_data;
    end
  end
endmodule

// File: rtl/rob_oldest_pick.sv
module rob_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [TAG_W-1:0] start,
  output logic             found,
  output logic [TAG_W-1:0] pick
);
  logic [TAG_W-1:0] cur;

  // scan from the youngest distance down so the oldest match is kept last
  always_comb begin
    found = 1'b0;
    pick  = start;
    cur   = start;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      cur = start + TAG_W'(k);
      if (cand[cur]) begin
        found = 1'b1;
        pick  = cur;
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH   = 8,
  parameter int NREG    = 8,
  parameter int XLEN    = 16,
  parameter int OPW     = 4,
  parameter int CAUSE_W = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1,
  localparam int RW     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [OPW-1:0]     alloc_op,
  input  logic [RW-1:0]      alloc_src1,
  input  logic [RW-1:0]      alloc_src2,
  input  logic               alloc_dst_en,
  input  logic [RW-1:0]      alloc_dst,
  output logic               alloc_ready,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic               issue_accept,
  output logic               issue_valid,
  output logic [TAG_W-1:0]   issue_tag,
  output logic [OPW-1:0]     issue_op,
  output logic [XLEN-1:0]    issue_val1,
  output logic [XLEN-1:0]    issue_val2,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  input  logic [XLEN-1:0]    res_data,
  input  logic [CAUSE_W-1:0] res_cause,
  output logic               cmt_valid,
  output logic [TAG_W-1:0]   cmt_tag,
  output logic               cmt_dst_en,
  output logic [RW-1:0]      cmt_dst,
  output logic [XLEN-1:0]    cmt_data,
  output logic               exc_valid,
  output logic [TAG_W-1:0]   exc_tag,
  output logic [CAUSE_W-1:0] exc_cause
);
  import rob_pkg::*;

  // ---------------- slot storage ----------------
  logic [DEPTH-1:0]   e_use, e_exec, e_done, e_rdy1, e_rdy2, e_den;
  logic [OPW-1:0]     e_op    [DEPTH];
  logic [TAG_W-1:0]   e_t1    [DEPTH];
  logic [TAG_W-1:0]   e_t2    [DEPTH];
  logic [XLEN-1:0]    e_v1    [DEPTH];
  logic [XLEN-1:0]    e_v2    [DEPTH];
  logic [XLEN-1:0]    e_data  [DEPTH];
  logic [RW-1:0]      e_dst   [DEPTH];
  logic [CAUSE_W-1:0] e_cause [DEPTH];

  // ---------------- pointers ----------------
  logic [PTR_W-1:0] head, tail;
  logic [TAG_W-1:0] hidx, tidx;
  logic             full, head_done, flush_now, commit_now, do_alloc, do_issue;

  assign hidx       = head[TAG_W-1:0];
  assign tidx       = tail[TAG_W-1:0];
  assign full       = (head[TAG_W] != tail[TAG_W]) && (hidx == tidx);
  assign head_done  = e_use[hidx] && e_done[hidx];
  assign flush_now  = head_done && (e_cause[hidx] != '0);
  assign commit_now = head_done && (e_cause[hidx] == '0);
  assign alloc_ready = !full && !flush_now;
  assign alloc_tag   = tidx;
  assign do_alloc    = alloc_valid && alloc_ready;
  assign do_issue    = issue_valid && issue_accept;

  // ---------------- operand resolution ----------------
  logic [RW-1:0]    s_reg  [2];
  logic             s_rt_v [2];
  logic [TAG_W-1:0] s_rt_t [2];
  logic [XLEN-1:0]  s_arf  [2];
  src_kind_e        s_kind [2];
  logic             s_rdy  [2];
  logic [XLEN-1:0]  s_val  [2];

  assign s_reg[0] = alloc_src1;
  assign s_reg[1] = alloc_src2;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      if (!s_rt_v[s])
        s_kind[s] = SRC_ARCH;
      else if (e_done[s_rt_t[s]])
        s_kind[s] = SRC_DONE;
      else if (res_valid && res_tag == s_rt_t[s])
        s_kind[s] = SRC_BCAST;
      else
        s_kind[s] = SRC_WAIT;
      case (s_kind[s])
        SRC_ARCH:  begin s_rdy[s] = 1'b1; s_val[s] = s_arf[s];           end
        SRC_DONE:  begin s_rdy[s] = 1'b1; s_val[s] = e_data[s_rt_t[s]];  end
        SRC_BCAST: begin s_rdy[s] = 1'b1; s_val[s] = res_data;           end
        default:   begin s_rdy[s] = 1'b0; s_val[s] = '0;                 end
      endcase
    end
  end

  rob_rename_table #(.NREG(NREG), .TAG_W(TAG_W)) u_alias (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush_now),
    .rd_a       (s_reg[0]),
    .rd_b       (s_reg[1]),
    .rd_a_valid (s_rt_v[0]),
    .rd_a_tag   (s_rt_t[0]),
    .rd_b_valid (s_rt_v[1]),
    .rd_b_tag   (s_rt_t[1]),
    .set_en     (do_alloc && alloc_dst_en),
    .set_reg    (alloc_dst),
    .set_tag    (tidx),
    .clr_en     (commit_now && e_den[hidx]),
    .clr_reg    (e_dst[hidx]),
    .clr_tag    (hidx)
  );

  rob_arf #(.NREG(NREG), .XLEN(XLEN)) u_arf (
    .clk       (clk),
    .rst       (rst),
    .rd_a      (s_reg[0]),
    .rd_b      (s_reg[1]),
    .rd_a_data (s_arf[0]),
    .rd_b_data (s_arf[1]),
    .wr_en     (commit_now && e_den[hidx]),
    .wr_reg    (e_dst[hidx]),
    .wr_data   (e_data[hidx])
  );

  // ---------------- issue selection ----------------
  logic [DEPTH-1:0] cand;
  logic             pick_found;
  logic [TAG_W-1:0] pick_idx;

  assign cand = e_use & ~e_exec & ~e_done & e_rdy1 & e_rdy2;

  rob_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .cand  (cand),
    .start (hidx),
    .found (pick_found),
    .pick  (pick_idx)
  );

  assign issue_valid = pick_found && !flush_now;
  assign issue_tag   = pick_idx;
  assign issue_op    = e_op[pick_idx];
  assign issue_val1  = e_v1[pick_idx];
  assign issue_val2  = e_v2[pick_idx];

  // ---------------- slot flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      e_use  <= '0;
      e_exec <= '0;
      e_done <= '0;
      e_rdy1 <= '0;
      e_rdy2 <= '0;
    end else if (flush_now) begin
      e_use <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (res_valid && e_use[i] && res_tag == TAG_W'(i))
          e_done[i] <= 1'b1;
        if (res_valid && e_use[i] && !e_rdy1[i] && e_t1[i] == res_tag)
          e_rdy1[i] <= 1'b1;
        if (res_valid && e_use[i] && !e_rdy2[i] && e_t2[i] == res_tag)
          e_rdy2[i] <= 1'b1;
        if (do_issue && issue_tag == TAG_W'(i))
          e_exec[i] <= 1'b1;
        if (commit_now && hidx == TAG_W'(i))
          e_use[i] <= 1'b0;
      end
      if (do_alloc) begin
        e_use[tidx]  <= 1'b1;
        e_exec[tidx] <= 1'b0;
        e_done[tidx] <= 1'b0;
        e_rdy1[tidx] <= s_rdy[0];
        e_rdy2[tidx] <= s_rdy[1];
      end
    end
  end

  // ---------------- slot payload (no reset) ----------------
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (res_valid && e_use[i] && !e_rdy1[i] && e_t1[i] == res_tag)
        e_v1[i] <= res_data;
      if (res_valid && e_use[i] && !e_rdy2[i] && e_t2[i] == res_tag)
        e_v2[i] <= res_data;
    end
    if (res_valid) begin
      e_data[res_tag]  <= res_data;
      e_cause[res_tag] <= res_cause;
    end
    if (do_alloc) begin
      e_op[tidx]  <= alloc_op;
      e_den[tidx] <= alloc_dst_en;
      e_dst[tidx] <= alloc_dst;
      e_t1[tidx]  <= s_rt_t[0];
      e_t2[tidx]  <= s_rt_t[1];
      e_v1[tidx]  <= s_val[0];
      e_v2[tidx]  <= s_val[1];
    end
  end

  // ---------------- pointers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
    end else if (flush_now) begin
      tail <= head;
    end else begin
      if (do_alloc)   tail <= tail + PTR_W'(1);
      if (commit_now) head <= head + PTR_W'(1);
    end
  end

  // ---------------- registered retirement / fault report ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid <= 1'b0;
      exc_valid <= 1'b0;
    end else begin
      cmt_valid <= commit_now;
      exc_valid <= flush_now;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_now) begin
      cmt_tag    <= hidx;
      cmt_dst_en <= e_den[hidx];
      cmt_dst    <= e_dst[hidx];
      cmt_data   <= e_data[hidx];
    end
    if (flush_now) begin
      exc_tag   <= hidx;
      exc_cause <= e_cause[hidx];
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             issue_accept,
  input logic             issue_valid,
  input logic [TAG_W-1:0] issue_tag,
  input logic             cmt_valid,
  input logic             exc_valid
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      AST_RESET_EMPTY: assert (alloc_ready && !issue_valid && !cmt_valid && !exc_valid); // R1
    end
  end

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=> (alloc_tag == $past(alloc_tag) + TAG_W'(1))); // R2

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_accept) |=> !(issue_valid && issue_tag == $past(issue_tag))); // R6

  AST_CMT_EXC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cmt_valid && exc_valid)); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (alloc_ready && !issue_valid)); // R8
endmodule

bind rob_core rob_core_chk #(.TAG_W(TAG_W)) u_rob_core_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_tag    (alloc_tag),
  .issue_accept (issue_accept),
  .issue_valid  (issue_valid),
  .issue_tag    (issue_tag),
  .cmt_valid    (cmt_valid),
  .exc_valid    (exc_valid)
);

// File: tb/test_rob_core.sv
module test_rob_core;
  localparam int DEPTH = 8;
  localparam int NREG  = 8;
  localparam int XLEN  = 16;
  localparam int OPW   = 4;
  localparam int CW    = 4;
  localparam int TW    = 3;
  localparam int RW    = 3;
  localparam int NPROG = 6;
  // program: {op, src1, src2, dst} one nibble each; result = src1 + src2 + op
  localparam logic [15:0] PROG [NPROG] = '{16'h3001, 16'h5112, 16'h1001,
                                           16'h2123, 16'h7202, 16'h4324};

  logic clk, rst;
  logic alloc_valid, alloc_dst_en, alloc_ready, issue_accept, issue_valid;
  logic [OPW-1:0] alloc_op, issue_op;
  logic [RW-1:0] alloc_src1, alloc_src2, alloc_dst, cmt_dst;
  logic [TW-1:0] alloc_tag, issue_tag, res_tag, cmt_tag, exc_tag;
  logic [XLEN-1:0] issue_val1, issue_val2, res_data, cmt_data;
  logic res_valid, cmt_valid, cmt_dst_en, exc_valid;
  logic [CW-1:0] res_cause, exc_cause;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .OPW(OPW), .CAUSE_W(CW)) i_rob_core (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_src1(alloc_src1), .alloc_src2(alloc_src2), .alloc_dst_en(alloc_dst_en),
    .alloc_dst(alloc_dst), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .issue_accept(issue_accept), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_op(issue_op), .issue_val1(issue_val1), .issue_val2(issue_val2),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .res_cause(res_cause),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dst_en(cmt_dst_en), .cmt_dst(cmt_dst),
    .cmt_data(cmt_data), .exc_valid(exc_valid), .exc_tag(exc_tag), .exc_cause(exc_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mon_k = 0;
  bit mon_on = 1'b0;
  int exp_val [NPROG];
  int exp_reg [NPROG];
  int model [NREG];
  logic [TW-1:0] stk_tag [DEPTH];
  logic [XLEN-1:0] stk_val [DEPTH];
  int sp, cyc, ncmt, csum;
  logic [TW-1:0] base, ta, tb, tc;
  logic [XLEN-1:0] pval;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_op = '0; alloc_src1 = '0; alloc_src2 = '0;
    alloc_dst_en = 0; alloc_dst = '0; issue_accept = 0;
    res_valid = 0; res_tag = '0; res_data = '0; res_cause = '0;
  endtask

  task automatic put(input int op, input int s1, input int s2, input bit den, input int d);
    alloc_valid = 1; alloc_op = OPW'(op); alloc_src1 = RW'(s1); alloc_src2 = RW'(s2);
    alloc_dst_en = den; alloc_dst = RW'(d);
  endtask

  // acts as a one-deep execution unit until the window drains
  task automatic drain(input int cycles, output int n, output int sum);
    bit pend = 0;
    bit npend;
    logic [TW-1:0] pt = '0, nt = '0;
    logic [XLEN-1:0] pv = '0, nv = '0;
    n = 0; sum = 0;
    repeat (cycles) begin
      if (cmt_valid) begin n++; sum += int'(cmt_data); end
      npend = issue_valid;
      if (issue_valid) begin
        issue_accept = 1; nt = issue_tag; nv = issue_val1 + issue_val2 + XLEN'(issue_op);
      end else issue_accept = 0;
      res_valid = pend; res_tag = pt; res_data = pv; res_cause = '0;
      pend = npend; pt = nt; pv = nv;
      nxt();
    end
    idle();
  endtask

  always @(negedge clk) begin
    if (mon_on && cmt_valid && mon_k < NPROG) begin
      chk("R7 commit data", int'(cmt_data), exp_val[mon_k]);
      chk("R7 commit dst", int'(cmt_dst), exp_reg[mon_k]);
      mon_k++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // sequential model of the program
    for (int r = 0; r < NREG; r++) model[r] = 0;
    for (int k = 0; k < NPROG; k++) begin
      exp_val[k] = (model[PROG[k][10:8]] + model[PROG[k][6:4]] + int'(PROG[k][15:12])) & 16'hFFFF;
      exp_reg[k] = int'(PROG[k][2:0]);
      model[PROG[k][2:0]] = exp_val[k];
    end

    idle();
    rst = 1;
    repeat (3) nxt();
    // R1 reset state
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_tag", int'(alloc_tag), 0);
    chk("R1 issue_valid", int'(issue_valid), 0);
    chk("R1 cmt_valid", int'(cmt_valid), 0);
    chk("R1 exc_valid", int'(exc_valid), 0);
    rst = 0;
    nxt();

    // table walk: R3 R4 R6 R7 with out-of-order (LIFO) result return
    mon_on = 1;
    for (int k = 0; k < NPROG; k++) begin
      put(int'(PROG[k][15:12]), int'(PROG[k][10:8]), int'(PROG[k][6:4]), 1, int'(PROG[k][2:0]));
      nxt();
    end
    idle();
    sp = 0; cyc = 0;
    while (mon_k < NPROG && cyc < 100) begin
      if (sp > 0 && (cyc % 2 == 1 || !issue_valid)) begin
        sp--;
        res_valid = 1; res_tag = stk_tag[sp]; res_data = stk_val[sp];
      end else res_valid = 0;
      if (issue_valid) begin
        issue_accept = 1; stk_tag[sp] = issue_tag;
        stk_val[sp] = issue_val1 + issue_val2 + XLEN'(issue_op); sp++;
      end else issue_accept = 0;
      nxt(); cyc++;
    end
    idle();
    nxt();
    chk("R7 all program slots retired", mon_k, NPROG);
    mon_on = 0;

    // R2 fill to full, stalled request ignored; R6 oldest first
    base = alloc_tag;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 alloc_tag sequence", int'(alloc_tag), (int'(base) + i) % DEPTH);
      put(i, 0, 0, 0, 0);
      nxt();
    end
    put(15, 0, 0, 0, 0);
    chk("R2 full blocks", int'(alloc_ready), 0);
    nxt();
    chk("R2 tag frozen when full", int'(alloc_tag), int'(base));
    idle();
    chk("R6 oldest offered", int'(issue_tag), int'(base));
    drain(60, ncmt, csum);
    chk("R2 retire count", ncmt, DEPTH);
    chk("R2 stalled request not written", csum, 28);
    chk("R2 empty again", int'(alloc_ready), 1);

    // R8 R9 fault flush
    ta = alloc_tag;
    put(0, 1, 1, 1, 5); nxt();
    put(0, 5, 0, 1, 6); nxt();
    put(0, 0, 0, 1, 5); nxt();
    idle();
    chk("R6 oldest ready offered", int'(issue_tag), int'(ta));
    issue_accept = 1; nxt();
    issue_accept = 0;
    res_valid = 1; res_tag = ta; res_data = 16'd99; res_cause = 4'd3; nxt();
    idle(); nxt();
    chk("R8 exc_valid", int'(exc_valid), 1);
    chk("R8 exc_cause", int'(exc_cause), 3);
    chk("R8 exc_tag", int'(exc_tag), int'(ta));
    chk("R8 no retire", int'(cmt_valid), 0);
    chk("R8 window empty", int'(alloc_tag), int'(ta));
    chk("R8 nothing offered", int'(issue_valid), 0);
    // R9 / R3: r5 alias must be gone, reads come from the architectural file
    put(0, 1, 5, 0, 0); nxt();
    idle();
    chk("R9 reader ready after flush", int'(issue_valid), 1);
    chk("R3 arch value r1", int'(issue_val1), exp_val[2]);
    chk("R9 arch value r5", int'(issue_val2), 0);
    drain(10, ncmt, csum);

    // R5 same-cycle broadcast capture; R7 retirement timing
    ta = alloc_tag;
    put(6, 0, 0, 1, 7); nxt();
    idle();
    issue_accept = 1; pval = issue_val1 + issue_val2 + XLEN'(issue_op); nxt();
    issue_accept = 0;
    tb = alloc_tag;
    put(0, 7, 7, 0, 0);
    res_valid = 1; res_tag = ta; res_data = pval; nxt();
    idle();
    chk("R5 reader offered", int'(issue_valid), 1);
    chk("R5 reader tag", int'(issue_tag), int'(tb));
    chk("R5 captured value", int'(issue_val1), 6);
    chk("R7 not yet retired", int'(cmt_valid), 0);
    nxt();
    chk("R7 retire one edge after result", int'(cmt_valid), 1);
    chk("R7 retired value", int'(cmt_data), 6);
    drain(10, ncmt, csum);

    // R10 alias kept for a younger writer; R4 wait then capture
    ta = alloc_tag;
    put(1, 0, 0, 1, 2); nxt();
    tb = alloc_tag;
    put(2, 0, 0, 1, 2);
    issue_accept = 1; nxt();
    alloc_valid = 0;
    chk("R6 younger writer offered", int'(issue_tag), int'(tb));
    nxt();
    issue_accept = 0;
    res_valid = 1; res_tag = ta; res_data = 16'd1; nxt();
    idle(); nxt();
    chk("R7 older writer retired", int'(cmt_data), 1);
    tc = alloc_tag;
    put(0, 2, 2, 0, 0); nxt();
    idle();
    chk("R10 reader waits on younger writer", int'(issue_valid), 0);
    res_valid = 1; res_tag = tb; res_data = 16'd2; nxt();
    idle();
    chk("R4 reader offered after broadcast", int'(issue_valid), 1);
    chk("R4 reader tag", int'(issue_tag), int'(tc));
    chk("R4 captured value", int'(issue_val1) + int'(issue_val2), 4);
    drain(10, ncmt, csum);
    chk("R7 remaining retire", ncmt, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule